// File: doc/BRIEF.md
# Nibble-Serial Firmware Memory Bus Target

This block is the target side of a 4-bit firmware memory bus. All fields move one nibble per rising clock edge. An active-low framing line marks the start of each cycle, and the start code on the data nibbles says whether the cycle is a read or a write. The target then takes in an identity nibble, a 28-bit address sent as seven nibbles and a size nibble. For a write, it also takes two data nibbles. A read is answered with a sync nibble followed by the addressed byte.

Only the last five address nibbles are decoded. Address bit 22 is the one exception: it sends the access either to a byte array that stands in for flash, or to a small bank of byte registers.

If the framing line drops while a cycle is running, the cycle is aborted. The target stays silent until the host sends an all-ones nibble. When idle, the target reports standby while the framing line is high, and ready while it is low.

Top module: `nfb_target`

## Requirements
- R1: While reset is asserted, and right after it is released, the target is idle: `bus_oe` is 0 and, with `frame_n` high, `is_standby` is 1.
- R2: A read cycle starts when `frame_n` is low at a rising edge and `bus_in` is 1101b. The field order is one identity nibble, 7 address nibbles (most significant first), one size nibble and 2 turnaround clocks. The target then drives a sync of 0000b for one clock, then the data byte low nibble first over two clocks, and then releases the bus for 2 turnaround clocks before going idle.
- R3: A write cycle starts with start code 1110b. After identity, address and size, the host sends two data nibbles (low first), then 2 turnaround clocks. The target drives one sync of 0000b and then 2 more turnaround clocks. The byte is stored, and a later read returns it.
- R4: Address bit 22 set selects the byte array; the array index is the low `MEM_AW` bits of address bits 19:0. Address bit 22 clear selects the register bank, indexed by address bits 19:0. No other bit of address nibbles 27:20 has any effect.
- R5: If the identity nibble differs from `id_strap`, the rest of that cycle is tracked but ignored: the bus is never driven and no storage changes.
- R6: Register addresses at or above `NREG` are not implemented. Writes to them are dropped, and reads from them return 00h.
- R7: `frame_n` low at any edge after the start edge aborts the cycle. The target then stops driving and ignores start codes until it samples 1111b on `bus_in`. After that it is idle and accepts cycles again.
- R8: In idle, `is_standby` equals `frame_n` and `is_ready` equals its inverse. Both are 0 while a cycle or an abort wait is in progress. `is_ready`, `is_standby` and `bus_oe` are never high together.
- R9: `bus_oe` is high only during the sync and read-data fields. It is never high during any turnaround clock.
- R10: In idle, `frame_n` low with a nibble that is not a start code starts no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, fields sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low cycle framing / abort line |
| bus_in | input | 4 | Nibble received from the bus |
| id_strap | input | 4 | Identity this target answers to |
| bus_out | output | 4 | Nibble driven onto the bus when enabled |
| bus_oe | output | 1 | Output enable for `bus_out` |
| is_ready | output | 1 | Idle with framing line low |
| is_standby | output | 1 | Idle with framing line high |

## Verification
A start code can arrive in the same clock as an abort: the host pulls `frame_n` low mid-address while `bus_in` carries 1101b. The bench provokes this and judges it by the status pins. The target must enter the abort wait rather than restart, and must keep ignoring a second start code until the 1111b nibble arrives. A read issued after recovery must then return the stored byte. An abort in the same clock as the target's own drive window is also provoked, just after the sync nibble, and `bus_oe` must fall on that edge.

// File: rtl/nfb_pkg.sv
package nfb_pkg;
   localparam int NIB_W     = 4;
   localparam int ADDR_NIBS = 7;
   localparam int DEC_NIBS  = 5;
   localparam int DEC_BITS  = DEC_NIBS * NIB_W;
   localparam int SEL_NIB   = 1;   // nibble carrying address bits 23:20
   localparam int SEL_BIT   = 2;   // bit 22 inside that nibble
   localparam int TAR_CLKS  = 2;
   localparam int DATA_NIBS = 2;

   localparam logic [NIB_W-1:0] CODE_RD    = 4'b1101;
   localparam logic [NIB_W-1:0] CODE_WR    = 4'b1110;
   localparam logic [NIB_W-1:0] CODE_ABORT = 4'b1111;
   localparam logic [NIB_W-1:0] CODE_SYNC  = 4'b0000;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ID, ST_ADDR, ST_SIZE, ST_RTAR, ST_RSYNC, ST_RDAT,
      ST_WDAT, ST_WTAR, ST_WSYNC, ST_ETAR, ST_ABORT
   } fsm_t;
endpackage

// File: rtl/nfb_parser.sv
module nfb_parser
   import nfb_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_n,
   input  logic [NIB_W-1:0]    bus_in,
   input  logic [NIB_W-1:0]    id_strap,
   output fsm_t                state_o,
   output logic                nib_hi_o,
   output logic                hit_o,
   output logic                mem_sel_o,
   output logic [DEC_BITS-1:0] addr_o,
   output logic                wr_en_o,
   output logic [7:0]          wr_data_o
);
   localparam int CNT_W = $clog2(ADDR_NIBS);

   if (TAR_CLKS > (1 << CNT_W) || DATA_NIBS > (1 << CNT_W)) begin : g_bad_cnt
      $error("field counter too narrow");
   end

   fsm_t                state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                rd_q, hit_q, msel_q, wr_en_q;
   logic [DEC_BITS-1:0] addr_q;
   logic [NIB_W-1:0]    lo_q;
   logic [7:0]          wdat_q;
   logic                cyc_active;

   assign cyc_active = (state_q != ST_IDLE) && (state_q != ST_ABORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rd_q    <= 1'b0;
         hit_q   <= 1'b0;
         msel_q  <= 1'b0;
         addr_q  <= '0;
         lo_q    <= '0;
         wdat_q  <= '0;
         wr_en_q <= 1'b0;
      end else begin
         wr_en_q <= 1'b0;
         if (cyc_active && !frame_n) begin
            state_q <= ST_ABORT;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (!frame_n && (bus_in == CODE_RD || bus_in == CODE_WR)) begin
                     rd_q    <= (bus_in == CODE_RD);
                     state_q <= ST_ID;
                  end
               end
               ST_ID: begin
                  hit_q   <= (bus_in == id_strap);
                  cnt_q   <= '0;
                  state_q <= ST_ADDR;
               end
               ST_ADDR: begin
                  if (cnt_q == CNT_W'(SEL_NIB)) msel_q <= bus_in[SEL_BIT];
                  addr_q <= {addr_q[DEC_BITS-NIB_W-1:0], bus_in};
                  cnt_q  <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(ADDR_NIBS-1)) state_q <= ST_SIZE;
               end
               ST_SIZE: begin
                  cnt_q   <= '0;
                  state_q <= rd_q ? ST_RTAR : ST_WDAT;
               end
               ST_RTAR, ST_WTAR, ST_ETAR: begin
                  if (cnt_q == CNT_W'(TAR_CLKS-1)) begin
                     cnt_q   <= '0;
                     state_q <= (state_q == ST_RTAR) ? ST_RSYNC :
                                (state_q == ST_WTAR) ? ST_WSYNC : ST_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_RSYNC, ST_WSYNC: begin
                  cnt_q   <= '0;
                  state_q <= (state_q == ST_RSYNC) ? ST_RDAT : ST_ETAR;
               end
               ST_RDAT: begin
                  if (cnt_q == CNT_W'(DATA_NIBS-1)) begin
                     cnt_q   <= '0;
                     state_q <= ST_ETAR;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_WDAT: begin
                  if (cnt_q == '0) begin
                     lo_q  <= bus_in;
                     cnt_q <= cnt_q + 1'b1;
                  end else begin
                     wdat_q  <= {bus_in, lo_q};
                     wr_en_q <= hit_q;
                     cnt_q   <= '0;
                     state_q <= ST_WTAR;
                  end
               end
               ST_ABORT: begin
                  if (bus_in == CODE_ABORT) state_q <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign state_o   = state_q;
   assign nib_hi_o  = (cnt_q != '0);
   assign hit_o     = hit_q;
   assign mem_sel_o = msel_q;
   assign addr_o    = addr_q;
   assign wr_en_o   = wr_en_q;
   assign wr_data_o = wdat_q;

   AST_ABORT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_active && !frame_n) |=> (state_q == ST_ABORT)); // R7
   AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ABORT && bus_in != CODE_ABORT) |=> (state_q == ST_ABORT)); // R7
endmodule

// File: rtl/nfb_mem.sv
module nfb_mem #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] arr_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) arr_q[addr] <= wdata;
   end

   assign rdata = arr_q[addr];

   AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R3
endmodule

// File: rtl/nfb_regs.sv
module nfb_regs #(
   parameter int NREG = 4,
   parameter int AW   = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   logic [NREG-1:0][7:0] terms;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            q <= '0;
         else if (wr_en && addr == AW'(g))      q <= wdata;
      end
      assign terms[g] = (addr == AW'(g)) ? q : 8'h00;
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NREG; i++) rdata = rdata | terms[i];
   end

   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr >= AW'(NREG)) |-> (rdata == 8'h00)); // R6
endmodule

// File: rtl/nfb_target.sv
module nfb_target
   import nfb_pkg::*;
#(
   parameter int MEM_AW = 6,
   parameter int NREG   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic [3:0] bus_in,
   input  logic [3:0] id_strap,
   output logic [3:0] bus_out,
   output logic       bus_oe,
   output logic       is_ready,
   output logic       is_standby
);
   if (MEM_AW < 1 || MEM_AW > DEC_BITS) begin : g_bad_aw
      $error("MEM_AW out of range");
   end
   if (NREG < 1 || NREG > 256) begin : g_bad_nreg
      $error("NREG out of range");
   end

   fsm_t                state;
   logic                nib_hi, hit, mem_sel, wr_en;
   logic [DEC_BITS-1:0] addr;
   logic [7:0]          wr_data, mem_rd, reg_rd, rd_byte;

   nfb_parser u_parser (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .bus_in    (bus_in),
      .id_strap  (id_strap),
      .state_o   (state),
      .nib_hi_o  (nib_hi),
      .hit_o     (hit),
      .mem_sel_o (mem_sel),
      .addr_o    (addr),
      .wr_en_o   (wr_en),
      .wr_data_o (wr_data)
   );

   nfb_mem #(.AW(MEM_AW)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en && mem_sel),
      .addr  (addr[MEM_AW-1:0]),
      .wdata (wr_data),
      .rdata (mem_rd)
   );

   nfb_regs #(.NREG(NREG), .AW(DEC_BITS)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en && !mem_sel),
      .addr  (addr),
      .wdata (wr_data),
      .rdata (reg_rd)
   );

   assign rd_byte = mem_sel ? mem_rd : reg_rd;

   always_comb begin
      bus_oe  = 1'b0;
      bus_out = CODE_SYNC;
      if (hit) begin
         case (state)
            ST_RSYNC, ST_WSYNC: bus_oe = 1'b1;
            ST_RDAT: begin
               bus_oe  = 1'b1;
               bus_out = nib_hi ? rd_byte[7:4] : rd_byte[3:0];
            end
            default: bus_oe = 1'b0;
         endcase
      end
   end

   assign is_standby = (state == ST_IDLE) && frame_n;
   assign is_ready   = (state == ST_IDLE) && !frame_n;

   AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> (bus_out == CODE_SYNC)); // R2
   AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({is_ready, is_standby, bus_oe})); // R8
endmodule

// File: tb/nfb_target_tb.sv
`timescale 1ns/1ps
module nfb_target_tb;
   localparam logic [3:0] STRAP = 4'h3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_n = 1'b1;
   logic [3:0] bus_in = 4'hF;
   logic [3:0] id_strap = STRAP;
   logic [3:0] bus_out;
   logic       bus_oe, is_ready, is_standby;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   nfb_target #(.MEM_AW(6), .NREG(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
      .id_strap(id_strap), .bus_out(bus_out), .bus_oe(bus_oe),
      .is_ready(is_ready), .is_standby(is_standby)
   );

   // {write, id, address, data}; for reads data is the expected byte
   localparam logic [40:0] VEC [12] = '{
      {1'b1, 4'h3, 28'h0400005, 8'hA5},
      {1'b1, 4'h3, 28'h0400012, 8'h3C},
      {1'b0, 4'h3, 28'hF400005, 8'hA5},
      {1'b0, 4'h3, 28'h0C00012, 8'h3C},
      {1'b1, 4'h3, 28'h0000002, 8'h77},
      {1'b0, 4'h3, 28'h0000002, 8'h77},
      {1'b0, 4'h3, 28'h0300002, 8'h77},
      {1'b1, 4'h3, 28'h0000009, 8'hEE},
      {1'b0, 4'h3, 28'h0000009, 8'h00},
      {1'b0, 4'h3, 28'h0400045, 8'hA5},
      {1'b1, 4'h5, 28'h0400005, 8'h11},
      {1'b0, 4'h3, 28'h0400005, 8'hA5}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic fr, input logic [3:0] nib);
      frame_n = fr;
      bus_in  = nib;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic header(input logic [3:0] code, input logic [3:0] id, input logic [27:0] a);
      step(1'b0, code);
      step(1'b1, id);
      for (int i = 0; i < 7; i++) step(1'b1, a[27-4*i -: 4]);
      step(1'b1, 4'h0);
   endtask

   task automatic rd_cycle(input logic [3:0] id, input logic [27:0] a,
                           input logic drive, output logic [7:0] got);
      header(4'hD, id, a);
      step(1'b1, 4'hF);
      check("R9 oe in read turnaround", {7'd0, bus_oe}, 8'd0);
      step(1'b1, 4'hF);
      check("R2 oe at sync", {7'd0, bus_oe}, {7'd0, drive});
      if (drive) check("R2 sync value", {4'd0, bus_out}, 8'h00);
      step(1'b1, 4'hF);
      got[3:0] = bus_out;
      check("R2 oe data low", {7'd0, bus_oe}, {7'd0, drive});
      step(1'b1, 4'hF);
      got[7:4] = bus_out;
      check("R2 oe data high", {7'd0, bus_oe}, {7'd0, drive});
      step(1'b1, 4'hF);
      check("R9 oe in end turnaround", {7'd0, bus_oe}, 8'd0);
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
   endtask

   task automatic wr_cycle(input logic [3:0] id, input logic [27:0] a,
                           input logic [7:0] d, input logic drive);
      header(4'hE, id, a);
      step(1'b1, d[3:0]);
      step(1'b1, d[7:4]);
      step(1'b1, 4'hF);
      check("R9 oe in write turnaround", {7'd0, bus_oe}, 8'd0);
      step(1'b1, 4'hF);
      check("R3 oe at write sync", {7'd0, bus_oe}, {7'd0, drive});
      if (drive) check("R3 write sync value", {4'd0, bus_out}, 8'h00);
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
      check("R3 idle after write", {7'd0, is_standby}, 8'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [7:0] got;
      repeat (3) @(negedge clk);
      check("R1 oe in reset", {7'd0, bus_oe}, 8'd0);
      check("R1 standby in reset", {7'd0, is_standby}, 8'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 standby after reset", {7'd0, is_standby}, 8'd1);
      check("R8 not ready with frame high", {7'd0, is_ready}, 8'd0);

      // R10: frame low with a non-start code
      step(1'b0, 4'h2);
      check("R8 ready with frame low", {7'd0, is_ready}, 8'd1);
      check("R10 no cycle from bad code", {7'd0, is_standby}, 8'd0);
      frame_n = 1'b1;
      #1;
      check("R10 still idle", {7'd0, is_standby}, 8'd1);
      step(1'b1, 4'h3);
      check("R10 idle after code", {7'd0, is_standby}, 8'd1);

      // vector table
      for (int v = 0; v < 12; v++) begin
         logic [40:0] e;
         e = VEC[v];
         if (e[40]) begin
            wr_cycle(e[39:36], e[35:8], e[7:0], e[39:36] == STRAP);
         end else begin
            rd_cycle(e[39:36], e[35:8], 1'b1, got);
            if (e[30] == 1'b0 && e[27:8] >= 20'd4)
               check("R6 unimplemented register reads zero", got, e[7:0]);
            else if (v == 11)
               check("R5 mismatched write left data", got, e[7:0]);
            else
               check("R3/R4 readback", got, e[7:0]);
         end
      end

      // R5: mismatched read never drives
      rd_cycle(4'h7, 28'h0400005, 1'b0, got);
      check("R5 idle after foreign read", {7'd0, is_standby}, 8'd1);

      // R7: abort mid-address with a read start code in the same clock
      step(1'b0, 4'hD);
      step(1'b1, 4'h3);
      step(1'b1, 4'h0);
      step(1'b1, 4'h4);
      step(1'b0, 4'hD);
      check("R7 abort not ready", {7'd0, is_ready}, 8'd0);
      check("R7 abort not standby", {7'd0, is_standby}, 8'd0);
      step(1'b0, 4'hE);
      step(1'b1, 4'h3);
      check("R7 start ignored while waiting", {7'd0, is_standby}, 8'd0);
      step(1'b1, 4'hF);
      check("R7 recovered", {7'd0, is_standby}, 8'd1);
      rd_cycle(4'h3, 28'h0400012, 1'b1, got);
      check("R7 read after recovery", got, 8'h3C);

      // R7: abort in the drive window
      header(4'hD, 4'h3, 28'h0400005);
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
      check("R2 drive before abort", {7'd0, bus_oe}, 8'd1);
      step(1'b0, 4'h0);
      check("R7 oe released on abort", {7'd0, bus_oe}, 8'd0);
      step(1'b1, 4'h0);
      check("R7 silent while waiting", {7'd0, bus_oe}, 8'd0);
      step(1'b1, 4'hF);
      check("R7 idle after abort nibble", {7'd0, is_standby}, 8'd1);

      // R6: unimplemented write did not land in register 1 alias
      rd_cycle(4'h3, 28'h0000001, 1'b1, got);
      check("R6 register 1 untouched", got, 8'h00);

      // R1: reset in the middle of a cycle
      step(1'b0, 4'hD);
      step(1'b1, 4'h3);
      rst_n = 1'b0;
      #1;
      check("R1 oe low in mid-cycle reset", {7'd0, bus_oe}, 8'd0);
      check("R1 standby in mid-cycle reset", {7'd0, is_standby}, 8'd1);
      @(negedge clk);
      rst_n = 1'b1;
      rd_cycle(4'h3, 28'h0000002, 1'b1, got);
      check("R1 registers cleared by reset", got, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule